// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Integer Core

This block is a compact processor that completes one instruction per enabled clock cycle. Each enabled cycle it fetches a 32-bit word from a private instruction store, decodes it, reads two operands from a 32-entry register file, computes a result in an integer ALU, optionally reads or writes a private data store, and commits the result and the next program counter on the rising clock edge. The instruction subset is add, sub, and, slt, addi, slti, lui, lw, sw, beq, bne, j, jal and jr.

The core is driven by a host through three port groups. A `run` input is the clock enable for the whole architectural state. While `run` is low, the host fills either store through a word load port. A debug port reads any register without disturbing execution. Any opcode or function code outside the subset executes as a no-op and sets a sticky flag that only reset clears.

Top module: `trc_core`

## Requirements
- R1: While `rst_n` is low and after it is released, `pc_o` is 0 and `illegal_o` is 0.
- R2: When `run` is low, the program counter and the flag keep their values. In that state a load-port write with `ld_sel`=0 goes to the instruction store and one with `ld_sel`=1 goes to the data store, at word index `ld_addr[..:2]`.
- R3: R-type words have op in [31:26]=0, rs in [25:21], rt in [20:16], rd in [15:11] and the function in [5:0]. Function 32 writes rs+rt to rd, 34 writes rs-rt and 36 writes rs AND rt.
- R4: slt (function 42) and slti (op 10) write 1 when the first operand is below the second as signed numbers, and 0 otherwise. The slti immediate in [15:0] is sign-extended.
- R5: addi (op 8) writes rs plus the sign-extended immediate to rt. lui (op 15) writes the immediate to rt[31:16] and zero to rt[15:0].
- R6: lw (op 35) loads rt from byte address rs+sext(imm). sw (op 43) stores rt at that address. The word index is address[..:2].
- R7: Register 0 always reads as zero, both in execution and through the debug port, and writes to it are discarded.
- R8: beq (op 4) and bne (op 5) go to PC+4+sext(imm)*4 when their equal or not-equal test holds, and to PC+4 otherwise.
- R9: j (op 2) and jal (op 3) go to {PC+4[31:28], target[25:0], 00}. jal also writes PC+4 to register 31.
- R10: jr (op 0, function 8) loads the PC from rs.
- R11: An unknown opcode or R-type function writes no register and no memory, advances the PC by 4, and sets `illegal_o`, which stays set until reset.
- R12: Every enabled cycle that executes a non-control instruction advances `pc_o` by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execution enable, one instruction per cycle |
| ld_en | input | 1 | Load port write strobe |
| ld_sel | input | 1 | Load target: 0 instruction store, 1 data store |
| ld_addr | input | 32 | Load byte address, word aligned |
| ld_data | input | 32 | Load data word |
| dbg_addr | input | 5 | Debug register index |
| dbg_data | output | 32 | Debug register value |
| pc_o | output | 32 | Current program counter |
| illegal_o | output | 1 | Sticky unknown-instruction flag |

## Verification
A wrong decode or a wrong writeback stays hidden in the register file until a later instruction uses the bad value or the debug port reads it. The bench therefore reads the affected registers right after each short program. A wrong next-PC shows up on `pc_o` in the very next cycle, and it also sends the rest of the program down the wrong path, which the bench sees as unexpected register contents. A wrong store shows up only when a later lw reads the same word back.

// File: rtl/trc_pkg.sv
package trc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_JAL   = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_LUI   = 6'd15;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_SLT = 6'd42;

  localparam int REG_AW  = 5;
  localparam logic [REG_AW-1:0] LINK_REG = 5'd31;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_SLT,
    ALU_LUI
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_RD,
    DST_RT,
    DST_LINK
  } dst_sel_e;

  typedef enum logic [1:0] {
    WB_ALU,
    WB_MEM,
    WB_LINK
  } wb_sel_e;

  typedef struct packed {
    alu_op_e  alu_op;
    logic     src_imm;
    logic     reg_we;
    dst_sel_e dst;
    wb_sel_e  wb;
    logic     mem_we;
    logic     br_eq;
    logic     br_ne;
    logic     jump;
    logic     jreg;
    logic     illegal;
  } ctrl_t;

endpackage

// File: rtl/trc_decode.sv
module trc_decode
  import trc_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);

  logic [5:0] opc;
  logic [5:0] fn;
  logic       unused_dec;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];
  assign unused_dec = ^instr[25:6];

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    ctrl.dst    = DST_RD;
    ctrl.wb     = WB_ALU;
    unique case (opc)
      OP_RTYPE: begin
        unique case (fn)
          FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_AND: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_AND; end
          FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
          FN_JR:  ctrl.jreg = 1'b1;
          default: ctrl.illegal = 1'b1;
        endcase
      end
      OP_ADDI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.dst     = DST_RT;
      end
      OP_SLTI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.dst     = DST_RT;
        ctrl.alu_op  = ALU_SLT;
      end
      OP_LUI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.dst     = DST_RT;
        ctrl.alu_op  = ALU_LUI;
      end
      OP_LW: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.dst     = DST_RT;
        ctrl.wb      = WB_MEM;
      end
      OP_SW: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin ctrl.alu_op = ALU_SUB; ctrl.br_eq = 1'b1; end
      OP_BNE: begin ctrl.alu_op = ALU_SUB; ctrl.br_ne = 1'b1; end
      OP_J:   ctrl.jump = 1'b1;
      OP_JAL: begin
        ctrl.jump   = 1'b1;
        ctrl.reg_we = 1'b1;
        ctrl.dst    = DST_LINK;
        ctrl.wb     = WB_LINK;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/trc_alu.sv
module trc_alu
  import trc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  localparam int HALF = XLEN / 2;

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_LUI: y = {b[HALF-1:0], {HALF{1'b0}}};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/trc_regfile.sv
module trc_regfile #(
  parameter int NREGS = 32,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(NREGS)-1:0] ra_a,
  input  logic [$clog2(NREGS)-1:0] ra_b,
  input  logic [$clog2(NREGS)-1:0] ra_c,
  output logic [W-1:0]             rd_a,
  output logic [W-1:0]             rd_b,
  output logic [W-1:0]             rd_c
);

  localparam int AW = $clog2(NREGS);

  logic [NREGS-1:0][W-1:0] rf_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign rf_q[i] = '0;
    end else begin : g_store
      logic         en;
      logic [W-1:0] q;
      assign en = we && (waddr == AW'(i));
      always_ff @(posedge clk) begin
        if (en) q <= wdata;
      end
      assign rf_q[i] = q;
    end
  end

  assign rd_a = rf_q[ra_a];
  assign rd_b = rf_q[ra_b];
  assign rd_c = rf_q[ra_c];

endmodule

// File: rtl/trc_wmem.sv
module trc_wmem #(
  parameter int DEPTH = 64,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/trc_core.sv
module trc_core
  import trc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREGS      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ld_en,
  input  logic            ld_sel,
  input  logic [XLEN-1:0] ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [4:0]      dbg_addr,
  output logic [XLEN-1:0] dbg_data,
  output logic [XLEN-1:0] pc_o,
  output logic            illegal_o
);

  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] pc_q, pc_d, pc4, br_tgt, jmp_tgt;
  logic            ill_q, ill_d;
  logic [31:0]     instr;
  ctrl_t           ctrl;
  logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_data;
  logic            alu_zero, take_br, rf_we, dm_we, im_we;
  logic [REG_AW-1:0] rf_waddr;
  logic [DAW-1:0]  dm_waddr;
  logic [XLEN-1:0] dm_wdata;
  logic            ctl_flow, dec_illegal;
  logic            unused_bits;

  assign unused_bits = ^{ld_addr, pc_q, alu_y};

  // instruction store
  assign im_we = ld_en && !ld_sel;

  trc_wmem #(.DEPTH(IMEM_WORDS), .W(32)) u_imem (
    .clk   (clk),
    .we    (im_we),
    .waddr (ld_addr[IAW+1:2]),
    .wdata (ld_data[31:0]),
    .raddr (pc_q[IAW+1:2]),
    .rdata (instr)
  );

  trc_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl)
  );

  assign ctl_flow    = ctrl.br_eq | ctrl.br_ne | ctrl.jump | ctrl.jreg;
  assign dec_illegal = ctrl.illegal;

  // operand read and writeback
  always_comb begin
    unique case (ctrl.dst)
      DST_RT:   rf_waddr = instr[20:16];
      DST_LINK: rf_waddr = LINK_REG;
      default:  rf_waddr = instr[15:11];
    endcase
  end

  assign rf_we = run && ctrl.reg_we;

  trc_regfile #(.NREGS(NREGS), .W(XLEN)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (wb_data),
    .ra_a  (instr[25:21]),
    .ra_b  (instr[20:16]),
    .ra_c  (dbg_addr),
    .rd_a  (rs_val),
    .rd_b  (rt_val),
    .rd_c  (dbg_data)
  );

  // execute
  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

  trc_alu #(.XLEN(XLEN)) u_alu (
    .op   (ctrl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data store: the load port has priority over a store
  assign dm_we    = (ld_en && ld_sel) || (run && !ld_en && ctrl.mem_we);
  assign dm_waddr = ld_en ? ld_addr[DAW+1:2] : alu_y[DAW+1:2];
  assign dm_wdata = ld_en ? ld_data : rt_val;

  trc_wmem #(.DEPTH(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[DAW+1:2]),
    .rdata (dm_rdata)
  );

  always_comb begin
    unique case (ctrl.wb)
      WB_MEM:  wb_data = dm_rdata;
      WB_LINK: wb_data = pc4;
      default: wb_data = alu_y;
    endcase
  end

  // next program counter
  assign pc4     = pc_q + XLEN'(4);
  assign br_tgt  = pc4 + {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};
  assign jmp_tgt = {pc4[XLEN-1:28], instr[25:0], 2'b00};
  assign take_br = (ctrl.br_eq && alu_zero) || (ctrl.br_ne && !alu_zero);

  always_comb begin
    if (ctrl.jreg)      pc_d = rs_val;
    else if (ctrl.jump) pc_d = jmp_tgt;
    else if (take_br)   pc_d = br_tgt;
    else                pc_d = pc4;
    ill_d = ill_q | ctrl.illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ill_q <= 1'b0;
    end else if (run) begin
      pc_q  <= pc_d;
      ill_q <= ill_d;
    end
  end

  assign pc_o      = pc_q;
  assign illegal_o = ill_q;

endmodule

// File: rtl/trc_core_chk.sv
module trc_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic [XLEN-1:0] pc_o,
  input logic            illegal_o,
  input logic [4:0]      dbg_addr,
  input logic [XLEN-1:0] dbg_data,
  input logic            ctl_flow,
  input logic            dec_illegal
);

  a_r12_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ctl_flow) |=> (pc_o == $past(pc_o) + XLEN'(4)));

  a_r12_pc_align: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[1:0] == 2'b00);

  a_r2_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc_o));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> illegal_o);

  a_r11_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dec_illegal) |=> illegal_o);

  a_r7_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == 5'd0) |-> (dbg_data == '0));

endmodule

bind trc_core trc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run),
  .pc_o        (pc_o),
  .illegal_o   (illegal_o),
  .dbg_addr    (dbg_addr),
  .dbg_data    (dbg_data),
  .ctl_flow    (ctl_flow),
  .dec_illegal (dec_illegal)
);

// File: tb/trc_core_bench.sv
`timescale 1ns/1ps
module trc_core_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic        ld_en;
  logic        ld_sel;
  logic [31:0] ld_addr;
  logic [31:0] ld_data;
  logic [4:0]  dbg_addr;
  logic [31:0] dbg_data;
  logic [31:0] pc_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  trc_core u_trc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .ld_en     (ld_en),
    .ld_sel    (ld_sel),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .dbg_addr  (dbg_addr),
    .dbg_data  (dbg_data),
    .pc_o      (pc_o),
    .illegal_o (illegal_o)
  );

  function automatic logic [31:0] enc_r(int fn, int rs, int rt, int rd);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  function automatic logic [31:0] enc_j(int op, int tgt);
    return {op[5:0], tgt[25:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic chk_reg(string req, int idx, logic [31:0] exp);
    dbg_addr = idx[4:0];
    #1;
    chk(req, dbg_data, exp);
  endtask

  task automatic load_word(logic sel, int byte_addr, logic [31:0] data);
    @(negedge clk);
    ld_en   = 1'b1;
    ld_sel  = sel;
    ld_addr = byte_addr;
    ld_data = data;
    @(negedge clk);
    ld_en   = 1'b0;
  endtask

  task automatic clear_imem();
    for (int k = 0; k < 64; k++) load_word(1'b0, k * 4, enc_r(32, 0, 0, 0));
  endtask

  task automatic reset_core();
    @(negedge clk);
    rst_n = 1'b0;
    run   = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_n(int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
  endtask

  // R1, R2, R7
  task automatic t_reset_hold();
    reset_core();
    chk("R1 pc after reset", pc_o, 32'd0);
    chk("R1 flag after reset", {31'd0, illegal_o}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R2 pc holds while halted", pc_o, 32'd0);
    chk_reg("R7 debug read of reg0", 0, 32'd0);
  endtask

  // R3, R4, R5, R12
  task automatic t_alu();
    clear_imem();
    load_word(1'b0,  0, enc_i(8, 0, 1, 5));
    load_word(1'b0,  4, enc_i(8, 0, 2, -3));
    load_word(1'b0,  8, enc_r(32, 1, 2, 3));
    load_word(1'b0, 12, enc_r(34, 1, 2, 4));
    load_word(1'b0, 16, enc_r(36, 1, 2, 5));
    load_word(1'b0, 20, enc_i(15, 0, 6, 16'h1234));
    load_word(1'b0, 24, enc_r(42, 2, 1, 7));
    load_word(1'b0, 28, enc_r(42, 1, 2, 8));
    load_word(1'b0, 32, enc_i(10, 2, 9, -2));
    load_word(1'b0, 36, enc_i(10, 1, 10, 4));
    reset_core();
    run_n(10);
    chk_reg("R5 addi positive", 1, 32'd5);
    chk_reg("R5 addi sign-extended", 2, 32'hFFFF_FFFD);
    chk_reg("R3 add", 3, 32'd2);
    chk_reg("R3 sub", 4, 32'd8);
    chk_reg("R3 and", 5, 32'd5);
    chk_reg("R5 lui", 6, 32'h1234_0000);
    chk_reg("R4 slt true signed", 7, 32'd1);
    chk_reg("R4 slt false signed", 8, 32'd0);
    chk_reg("R4 slti negative imm", 9, 32'd1);
    chk_reg("R4 slti false", 10, 32'd0);
    chk("R12 pc after ten steps", pc_o, 32'd40);
  endtask

  // R6, R2 data-store load
  task automatic t_mem();
    clear_imem();
    load_word(1'b1, 12, 32'hCAFE_BABE);
    load_word(1'b1,  4, 32'h0);
    load_word(1'b0,  0, enc_i(8, 0, 1, 8));
    load_word(1'b0,  4, enc_i(35, 1, 2, 4));
    load_word(1'b0,  8, enc_i(43, 1, 2, -4));
    load_word(1'b0, 12, enc_i(35, 0, 3, 4));
    reset_core();
    run_n(4);
    chk_reg("R6 lw base plus offset", 2, 32'hCAFE_BABE);
    chk_reg("R6 sw then lw negative offset", 3, 32'hCAFE_BABE);
    chk("R12 pc after memory ops", pc_o, 32'd16);
  endtask

  // R7
  task automatic t_zero();
    clear_imem();
    load_word(1'b0, 0, enc_i(8, 0, 1, 9));
    load_word(1'b0, 4, enc_i(8, 0, 0, 7));
    load_word(1'b0, 8, enc_r(32, 1, 1, 0));
    load_word(1'b0, 12, enc_r(32, 0, 0, 1));
    reset_core();
    run_n(4);
    chk_reg("R7 reg0 ignores writes", 0, 32'd0);
    chk_reg("R7 reg0 reads zero in execution", 1, 32'd0);
  endtask

  // R8
  task automatic t_branch();
    clear_imem();
    load_word(1'b0,  0, enc_i(8, 0, 3, 16'h99));
    load_word(1'b0,  4, enc_i(8, 0, 1, 1));
    load_word(1'b0,  8, enc_i(8, 0, 2, 1));
    load_word(1'b0, 12, enc_i(4, 1, 2, 2));
    load_word(1'b0, 16, enc_i(8, 0, 3, 16'h11));
    load_word(1'b0, 20, enc_i(8, 0, 3, 16'h22));
    load_word(1'b0, 24, enc_i(5, 1, 2, 5));
    load_word(1'b0, 28, enc_i(8, 0, 4, 16'h33));
    load_word(1'b0, 32, enc_i(4, 0, 0, 1));
    load_word(1'b0, 36, enc_i(8, 0, 4, 16'h44));
    load_word(1'b0, 40, enc_i(8, 0, 5, 16'h55));
    load_word(1'b0, 44, enc_i(5, 5, 0, -12));
    reset_core();
    run_n(8);
    chk("R8 pc after taken forward branches", pc_o, 32'd44);
    chk_reg("R8 beq taken skips", 3, 32'h99);
    chk_reg("R8 bne not taken falls through", 4, 32'h33);
    chk_reg("R8 target reached", 5, 32'h55);
    run_n(1);
    chk("R8 backward bne to zero", pc_o, 32'd0);
  endtask

  // R9, R10
  task automatic t_jump();
    clear_imem();
    load_word(1'b0,  0, enc_j(3, 5));
    load_word(1'b0,  4, enc_j(2, 8));
    load_word(1'b0,  8, enc_i(8, 0, 8, 16'hBAD));
    load_word(1'b0, 20, enc_i(8, 0, 7, 16'h77));
    load_word(1'b0, 24, enc_r(8, 31, 0, 0));
    load_word(1'b0, 32, enc_i(8, 0, 8, 16'h88));
    load_word(1'b0, 36, enc_i(8, 0, 9, 48));
    load_word(1'b0, 40, enc_r(8, 9, 0, 0));
    load_word(1'b0, 44, enc_i(8, 0, 8, 16'hBAD));
    reset_core();
    run_n(1);
    chk("R9 jal target", pc_o, 32'd20);
    run_n(6);
    chk_reg("R9 jal link value", 31, 32'd4);
    chk_reg("R9 jal body ran", 7, 32'h77);
    chk_reg("R9 j skipped word", 8, 32'h88);
    chk("R10 jr to register", pc_o, 32'd48);
  endtask

  // R11
  task automatic t_illegal();
    clear_imem();
    load_word(1'b0,  0, enc_i(8, 0, 1, 16'h10));
    load_word(1'b0,  4, enc_i(8, 0, 2, 16'h20));
    load_word(1'b0,  8, enc_i(63, 0, 1, 1));
    load_word(1'b0, 12, enc_r(63, 0, 0, 2));
    load_word(1'b0, 16, enc_i(8, 0, 3, 3));
    reset_core();
    run_n(2);
    chk("R11 flag clear before bad word", {31'd0, illegal_o}, 32'd0);
    run_n(1);
    chk("R11 flag set by bad opcode", {31'd0, illegal_o}, 32'd1);
    chk("R11 bad opcode advances pc", pc_o, 32'd12);
    run_n(2);
    chk("R11 flag sticky", {31'd0, illegal_o}, 32'd1);
    chk_reg("R11 bad opcode wrote nothing", 1, 32'h10);
    chk_reg("R11 bad function wrote nothing", 2, 32'h20);
    chk_reg("R11 execution continues", 3, 32'd3);
    reset_core();
    chk("R1 reset clears flag", {31'd0, illegal_o}, 32'd0);
  endtask

  initial begin
    rst_n    = 1'b0;
    run      = 1'b0;
    ld_en    = 1'b0;
    ld_sel   = 1'b0;
    ld_addr  = '0;
    ld_data  = '0;
    dbg_addr = '0;
    t_reset_hold();
    t_alu();
    t_mem();
    t_zero();
    t_branch();
    t_jump();
    t_illegal();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule